// File: doc/BRIEF.md
# Memory Array Integrity Signature Checker

This block sits beside an on-chip memory array and, when software asks, reads every word of a chosen set of sectors and compresses each word into a 160-bit multiple-input signature register. Software first unlocks the test mode by writing a password to the control register. It then chooses sectors through two bitmaps, seeds the signature and starts the sweep. When the done bit is set, it reads the five signature words and compares them with a value it has recorded earlier. The block does not make that comparison.

The array holds 42 sectors: 16 low, 16 mid and 10 high. Each sector holds `SECT_WORDS` words of 160 bits, made of 128 data bits and 32 check bits. The array is modelled as a synchronous ROM whose contents are computed from the address. The sweep owns the array while it runs. Every host read issued during that time gets a bus error and no data. The walk inside each sector is either linear or bit-reversed. Because the signature register is not commutative, the two orders give different signatures.

Top module: `mem_sig_sweep`

## Requirements
- R1: A register write of exactly 0xF9F99999 to offset 0 sets control bit 31 (unlocked), which stays set until reset. Before unlock, every write to offset 0 leaves bits [2:0] at 0 and starts nothing. No other written value sets bit 31.
- R2: Register map after reset, all zero:
  - offset 0: control. Bit 31 unlocked, bit 2 order select, bit 1 sweep enable, bit 0 done.
  - offset 1: low/mid select. Bits [15:0] select low sectors 0..15 and bits [31:16] select mid sectors 0..15.
  - offset 2: high select. Bits [9:0] select high sectors 0..9.
  - offsets 3..7: signature words 0..4, where word k is signature bits [32k+31:32k].
- R3: A write of bit 1 = 1 to offset 0 while unlocked and idle starts a sweep. Bit 0 reads 0 while the sweep runs and 1 once the signature is final.
- R4: Each array word W is folded as sig = {sig[158:0],0} ^ W ^ (sig[159] ? FB : 0), where FB has bits 0, 2, 3 and 5 set.
  - Word W at address a is {check, d3, d2, d1, d0}, where dj = (a+1)*0x9E3779B1 + j*0x7F4A7C15 mod 2^32 and check = d0^d1^d2^d3.
  - Sector index 0..15 is low, 16..31 is mid and 32..41 is high. The address is index*SECT_WORDS + offset.
- R5: With order select 0, selected sectors are visited in ascending index order, and offsets within each sector ascend.
- R6: With order select 1, the offsets within each sector are visited in bit-reversed order (0,2,1,3 for four words). The order bit is captured when the sweep starts.
- R7: A host read request is answered one cycle later with host_rvalid = 1.
  - During a sweep, host_err = 1 and host_rdata = 0.
  - Otherwise, host_err = 0 and host_rdata = bits [127:0] of the word at host_addr.
- R8: Any value written to the signature words before start is the seed, including zero. Reruns over the same seed and selection give identical signatures.
- R9: Writing bit 1 = 0 during a sweep aborts it. Done stays 0 and host reads succeed again from the next request.
- R10: Writing bit 1 = 0 after done returns the block to idle and clears done. The signature stays readable and unchanged.
- R11: With no sector selected, done reads 1 one cycle after the start write, and the signature equals the seed.
- R12: Writes to the select registers and the signature words are ignored while a sweep runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| host_req | input | 1 | Host array read request |
| host_addr | input | 8 | Host array word address |
| host_rvalid | output | 1 | Host read response valid, one cycle after request |
| host_err | output | 1 | Host read terminated with error |
| host_rdata | output | 128 | Host read data, zero on error |

## Verification
The bench runs every single-sector selection, using both walk orders, and several multi-sector patterns. It checks each signature against a model built from the fold rule. A design that swapped the walk order, skipped or repeated a sector, or dropped the last pipelined word would miss the expected signature. An empty selection must be done one cycle after start with the seed left intact; a finder that scanned sectors one per cycle would raise done far too late. The bench also covers three more cases:
- A write before unlock, which must not start a sweep.
- An abort in the middle of a sweep, which must leave done low and lift the read error.
- Writes to the signature and select registers during a sweep, which must be dropped; a design that accepted them would corrupt the final signature.

// File: rtl/mss_pkg.sv
package mss_pkg;
    localparam int SIG_W   = 160;
    localparam int DATA_W  = 128;
    localparam int LOW_N   = 16;
    localparam int MID_N   = 16;
    localparam logic [31:0]      UNLOCK_KEY = 32'hF9F99999;
    localparam logic [SIG_W-1:0] FB_MASK    = SIG_W'(32'h0000_002D);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} sweep_st_e;

    function automatic logic [SIG_W-1:0] rom_word(input logic [31:0] a);
        logic [31:0] d [4];
        for (int j = 0; j < 4; j++) begin
            d[j] = (a + 32'd1) * 32'h9E3779B1 + 32'(j) * 32'h7F4A7C15;
        end
        return {d[0] ^ d[1] ^ d[2] ^ d[3], d[3], d[2], d[1], d[0]};
    endfunction
endpackage

// File: rtl/mss_rom.sv
module mss_rom #(
    parameter int AW = 8
) (
    input  logic                     clk,
    input  logic [AW-1:0]            addr,
    output logic [mss_pkg::SIG_W-1:0] q
);
    always_ff @(posedge clk) begin
        q <= mss_pkg::rom_word(32'(addr));
    end
endmodule

// File: rtl/mss_sector_pick.sv
module mss_sector_pick #(
    parameter int NS = 42,
    parameter int SW = 6
) (
    input  logic [NS-1:0] mask,
    input  logic [SW-1:0] from,
    output logic          found,
    output logic [SW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from))) begin
                found = 1'b1;
                idx   = SW'(i);
            end
        end
    end
endmodule

// File: rtl/mss_misr_step.sv
module mss_misr_step
    import mss_pkg::*;
(
    input  logic [SIG_W-1:0] sig,
    input  logic [SIG_W-1:0] word,
    output logic [SIG_W-1:0] nxt
);
    always_comb begin
        nxt = {sig[SIG_W-2:0], 1'b0} ^ word;
        if (sig[SIG_W-1]) begin
            nxt = nxt ^ FB_MASK;
        end
    end
endmodule

// File: rtl/mem_sig_sweep.sv
module mem_sig_sweep
    import mss_pkg::*;
#(
    parameter int SECT_WORDS = 4,
    parameter int HIGH_N     = 10,
    localparam int NSECT     = LOW_N + MID_N + HIGH_N,
    localparam int SW        = $clog2(NSECT),
    localparam int OW        = $clog2(SECT_WORDS),
    localparam int AW        = SW + OW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              host_req,
    input  logic [AW-1:0]     host_addr,
    output logic              host_rvalid,
    output logic              host_err,
    output logic [DATA_W-1:0] host_rdata
);
    typedef struct packed {
        sweep_st_e         st;
        logic              unl;
        logic              seq;
        logic              aie;
        logic              seq_run;
        logic [31:0]       lm;
        logic [HIGH_N-1:0] hi;
        logic [SIG_W-1:0]  sig;
        logic [SW-1:0]     sect;
        logic              have;
        logic [OW-1:0]     off;
        logic              rdv;
        logic              rsp_v;
        logic              rsp_e;
    } state_t;

    state_t q, d;

    logic              run_w, done_w, unl_w;
    logic [SIG_W-1:0]  sig_w;
    logic [SIG_W-1:0]  rom_q, fold_w;
    logic [OW-1:0]     off_rev, off_eff;
    logic [AW-1:0]     rom_addr;
    logic [SW-1:0]     pick_from, pick_idx;
    logic              pick_found;

    assign run_w  = (q.st == ST_RUN);
    assign done_w = (q.st == ST_DONE);
    assign unl_w  = q.unl;
    assign sig_w  = q.sig;

    for (genvar b = 0; b < OW; b++) begin : g_rev
        assign off_rev[b] = q.off[OW-1-b];
    end

    assign off_eff   = q.seq_run ? off_rev : q.off;
    assign rom_addr  = run_w ? {q.sect, off_eff} : host_addr;
    assign pick_from = run_w ? q.sect + SW'(1) : '0;

    mss_rom #(.AW(AW)) u_rom (
        .clk  (clk),
        .addr (rom_addr),
        .q    (rom_q)
    );

    mss_sector_pick #(.NS(NSECT), .SW(SW)) u_pick (
        .mask  ({q.hi, q.lm}),
        .from  (pick_from),
        .found (pick_found),
        .idx   (pick_idx)
    );

    mss_misr_step u_misr (
        .sig  (q.sig),
        .word (rom_q),
        .nxt  (fold_w)
    );

    always_comb begin
        d       = q;
        d.rsp_v = host_req;
        d.rsp_e = host_req && run_w;

        if (run_w) begin
            if (q.rdv) begin
                d.sig = fold_w;
            end
            d.rdv = q.have;
            if (q.have) begin
                d.off = q.off + OW'(1);
                if (q.off == OW'(SECT_WORDS - 1)) begin
                    d.off  = '0;
                    d.sect = pick_idx;
                    d.have = pick_found;
                end
            end else if (!q.rdv) begin
                d.st = ST_DONE;
            end
        end

        if (reg_wr) begin
            case (reg_addr)
                3'd0: begin
                    if (reg_wdata == UNLOCK_KEY) begin
                        d.unl = 1'b1;
                    end else if (q.unl) begin
                        d.seq = reg_wdata[2];
                        d.aie = reg_wdata[1];
                        if (reg_wdata[1] && !q.aie && q.st == ST_IDLE) begin
                            d.st      = ST_RUN;
                            d.seq_run = reg_wdata[2];
                            d.sect    = pick_idx;
                            d.have    = pick_found;
                            d.off     = '0;
                            d.rdv     = 1'b0;
                        end else if (!reg_wdata[1]) begin
                            d.st   = ST_IDLE;
                            d.have = 1'b0;
                            d.rdv  = 1'b0;
                        end
                    end
                end
                3'd1: if (!run_w) d.lm = reg_wdata;
                3'd2: if (!run_w) d.hi = reg_wdata[HIGH_N-1:0];
                default: begin
                    if (!run_w) begin
                        for (int k = 0; k < 5; k++) begin
                            if (reg_addr == 3'(k + 3)) begin
                                d.sig[32*k +: 32] = reg_wdata;
                            end
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            3'd0:    reg_rdata = {q.unl, 28'd0, q.seq, q.aie, done_w};
            3'd1:    reg_rdata = q.lm;
            3'd2:    reg_rdata = 32'(q.hi);
            3'd3:    reg_rdata = q.sig[31:0];
            3'd4:    reg_rdata = q.sig[63:32];
            3'd5:    reg_rdata = q.sig[95:64];
            3'd6:    reg_rdata = q.sig[127:96];
            default: reg_rdata = q.sig[159:128];
        endcase
    end

    assign host_rvalid = q.rsp_v;
    assign host_err    = q.rsp_v && q.rsp_e;
    assign host_rdata  = (q.rsp_v && !q.rsp_e) ? rom_q[DATA_W-1:0] : '0;
endmodule

// File: rtl/mem_sig_sweep_chk.sv
module mem_sig_sweep_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         running,
    input logic         done,
    input logic         unl,
    input logic         sig_wr,
    input logic [159:0] sig,
    input logic         host_req,
    input logic         host_rvalid,
    input logic         host_err,
    input logic [127:0] host_rdata
);
    AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unl |=> unl); // R1
    AST_LOCKED_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !unl |-> !running); // R1
    AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(running)); // R3
    AST_ERR_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && running) |=> (host_rvalid && host_err)); // R7
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> (host_rdata == '0)); // R7
    AST_NO_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !running) |=> (host_rvalid && !host_err)); // R9
    AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !sig_wr) |=> $stable(sig)); // R8
endmodule

bind mem_sig_sweep mem_sig_sweep_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .running     (run_w),
    .done        (done_w),
    .unl         (unl_w),
    .sig_wr      (reg_wr && (reg_addr >= 3'd3)),
    .sig         (sig_w),
    .host_req    (host_req),
    .host_rvalid (host_rvalid),
    .host_err    (host_err),
    .host_rdata  (host_rdata)
);

// File: tb/mem_sig_sweep_tb_top.sv
module mem_sig_sweep_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSECT = 42;
    localparam int SWD = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         host_req = 1'b0;
    logic [7:0]   host_addr = '0;
    logic         host_rvalid, host_err;
    logic [127:0] host_rdata;

    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mem_sig_sweep dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_req(host_req),
        .host_addr(host_addr), .host_rvalid(host_rvalid), .host_err(host_err),
        .host_rdata(host_rdata)
    );

    function automatic logic [159:0] m_word(input int a);
        logic [31:0] w [4];
        for (int j = 0; j < 4; j++) begin
            w[j] = 32'(a + 1) * 32'h9E3779B1 + 32'(j) * 32'h7F4A7C15;
        end
        return {w[0] ^ w[1] ^ w[2] ^ w[3], w[3], w[2], w[1], w[0]};
    endfunction

    function automatic logic [159:0] m_fold(input logic [159:0] s, input logic [159:0] w);
        logic [159:0] n;
        n = {s[158:0], 1'b0} ^ w;
        if (s[159]) n = n ^ 160'h2D;
        return n;
    endfunction

    function automatic logic [159:0] m_sweep(input logic [159:0] seed, input logic [31:0] lm,
                                             input logic [9:0] hi, input logic seq);
        logic [41:0]  sel;
        logic [159:0] s;
        sel = {hi, lm};
        s = seed;
        for (int i = 0; i < NSECT; i++) begin
            if (sel[i]) begin
                for (int k = 0; k < SWD; k++) begin
                    int o;
                    o = seq ? ((k & 1) * 2 + (k >> 1)) : k;
                    s = m_fold(s, m_word(i * SWD + o));
                end
            end
        end
        return s;
    endfunction

    task automatic check(input string tag, input logic [159:0] act, input logic [159:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd_sig(output logic [159:0] s);
        logic [31:0] v;
        for (int k = 0; k < 5; k++) begin
            rd(3'(k + 3), v);
            s[32*k +: 32] = v;
        end
    endtask

    task automatic wait_done(output logic ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int c = 0; c < 400 && !ok; c++) begin
            rd(3'd0, v);
            if (v[0]) ok = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic host_read(input logic [7:0] a, output logic v, output logic e,
                             output logic [127:0] dat);
        host_req = 1'b1; host_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        v = host_rvalid; e = host_err; dat = host_rdata;
    endtask

    task automatic sweep(input string tag, input logic [159:0] seed, input logic [31:0] lm,
                         input logic [9:0] hi, input logic seq);
        logic ok;
        logic [159:0] s;
        for (int k = 0; k < 5; k++) wr(3'(k + 3), seed[32*k +: 32]);
        wr(3'd1, lm);
        wr(3'd2, 32'(hi));
        wr(3'd0, {29'd0, seq, 2'b10});
        wait_done(ok);
        check({tag, " done seen R3"}, 160'(ok), 160'd1);
        rd_sig(s);
        check(tag, s, m_sweep(seed, lm, hi, seq));
        wr(3'd0, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R3 actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0]  v;
        logic [159:0] s, s2, exp_s;
        logic         hv, he, ok;
        logic [127:0] hd;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check($sformatf("R2 reset reg %0d", a), 160'(v), 160'd0);
        end

        // R1: locked writes ignored, bit 31 not writable
        wr(3'd0, 32'h0000_0006);
        rd(3'd0, v);
        check("R1 locked write ignored", 160'(v), 160'd0);
        wr(3'd0, 32'h8000_0002);
        rd(3'd0, v);
        check("R1 bit31 not settable", 160'(v), 160'd0);
        repeat (3) @(negedge clk);
        rd(3'd0, v);
        check("R1 no sweep while locked", 160'(v), 160'd0);
        wr(3'd0, 32'hF9F9_9999);
        rd(3'd0, v);
        check("R1 unlock", 160'(v), 160'h8000_0000);

        // R2 register readback
        wr(3'd1, 32'h1234_5678);
        rd(3'd1, v);
        check("R2 lowmid readback", 160'(v), 160'h1234_5678);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v);
        check("R2 high readback", 160'(v), 160'h3FF);

        // R7 idle host read
        host_read(8'd5, hv, he, hd);
        check("R7 idle read", {hv, he, hd}, {1'b1, 1'b0, m_word(5)[127:0]});
        host_read(8'd167, hv, he, hd);
        check("R7 idle read last", {hv, he, hd}, {1'b1, 1'b0, m_word(167)[127:0]});

        // R11 empty selection
        s = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888, 32'h9999_AAAA};
        for (int k = 0; k < 5; k++) wr(3'(k + 3), s[32*k +: 32]);
        wr(3'd1, 32'd0);
        wr(3'd2, 32'd0);
        wr(3'd0, 32'h2);
        rd(3'd0, v);
        check("R11 not done at start", 160'(v[0]), 160'd0);
        @(negedge clk);
        rd(3'd0, v);
        check("R11 done one cycle later", 160'(v[0]), 160'd1);
        rd_sig(s2);
        check("R11 seed kept", s2, s);
        wr(3'd0, 32'd0);

        // R5, R8: example selection, zero seed, rerun identical
        sweep("R5 L2-L4,M0 linear", 160'd0, 32'h0001_001C, 10'd0, 1'b0);
        rd_sig(s);
        sweep("R8 rerun", 160'd0, 32'h0001_001C, 10'd0, 1'b0);
        rd_sig(s2);
        check("R8 rerun identical", s2, s);
        sweep("R6 L2-L4,M0 bitrev", 160'd0, 32'h0001_001C, 10'd0, 1'b1);
        rd_sig(s2);
        n_tests++;
        if (s2 === s) begin
            n_fail++;
            $display("FAIL R6 order had no effect actual=%h expected=not %h", s2, s);
        end
        sweep("R4 all high seeded", {5{32'hA5A5_5A5A}}, 32'd0, 10'h3FF, 1'b0);
        sweep("R5 all sectors", {5{32'hFFFF_FFFF}}, 32'hFFFF_FFFF, 10'h3FF, 1'b0);
        sweep("R6 all sectors bitrev", 160'd7, 32'hFFFF_FFFF, 10'h3FF, 1'b1);
        sweep("R5 sparse", 160'h1, 32'h8001_4002, 10'h201, 1'b0);
        sweep("R6 sparse", 160'h1, 32'h8001_4002, 10'h201, 1'b1);

        // R4 every single sector, alternating order
        for (int i = 0; i < NSECT; i++) begin
            logic [41:0] m;
            m = 42'd1 << i;
            sweep($sformatf("R4 single sector %0d", i), {5{32'(i)}}, m[31:0], m[41:32], i[0]);
        end

        // R7 error during sweep, R12 writes ignored
        for (int k = 0; k < 5; k++) wr(3'(k + 3), 32'h0BAD_0000 + 32'(k));
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'h3FF);
        wr(3'd0, 32'h2);
        host_read(8'd3, hv, he, hd);
        check("R7 read error in sweep", {hv, he, hd}, {1'b1, 1'b1, 128'd0});
        rd(3'd0, v);
        check("R3 done low while running", 160'(v[0]), 160'd0);
        wr(3'd3, 32'hDEAD_BEEF);
        wr(3'd1, 32'd0);
        wr(3'd2, 32'd0);
        wait_done(ok);
        rd_sig(s);
        exp_s = m_sweep({32'h0BAD_0004, 32'h0BAD_0003, 32'h0BAD_0002, 32'h0BAD_0001,
                         32'h0BAD_0000}, 32'hFFFF_FFFF, 10'h3FF, 1'b0);
        check("R12 sig write ignored", s, exp_s);
        rd(3'd1, v);
        check("R12 select write ignored", 160'(v), 160'hFFFF_FFFF);

        // R10 clear after done
        wr(3'd0, 32'd0);
        rd(3'd0, v);
        check("R10 idle after clear", 160'(v), 160'h8000_0000);
        rd_sig(s2);
        check("R10 sig kept", s2, exp_s);

        // R9 abort
        wr(3'd0, 32'h2);
        repeat (5) @(negedge clk);
        wr(3'd0, 32'd0);
        rd(3'd0, v);
        check("R9 abort ctl", 160'(v), 160'h8000_0000);
        host_read(8'd7, hv, he, hd);
        check("R9 read ok after abort", {hv, he, hd}, {1'b1, 1'b0, m_word(7)[127:0]});
        repeat (200) @(negedge clk);
        rd(3'd0, v);
        check("R9 done stays low", 160'(v[0]), 160'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule